// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a small programmable logic device. It receives an already-summed product-term result, a per-cell output-enable term, two shared initialisation terms (an asynchronous clear and a synchronous set), two candidate clocks, a four-bit configuration word, a preload port and the two halves of a bidirectional pad. It produces the pad drive value, the pad enable and one feedback signal that returns into the logic array.

The configuration word chooses whether the pad shows the flip-flop or the raw sum, which polarity the pad uses, and which of the two clocks the flip-flop samples on. Its top bit picks the feedback source. With that bit set, a registered cell feeds back its register and a combinational cell feeds back its pin. With that bit clear, the two choices swap. The pad is split into `pad_in`, `pad_out` and `pad_oe`, so the cell can be built in a core without tri-state nets. A preload port lets test logic write any state straight into the flip-flop, unless a security flag blocks it.

Top module: `pldc_out_cell`

## Requirements
- R1: `cfg[1]` = 1 selects combinational output: `pad_out` follows `sop_term` in the same cycle, with no clock edge. `cfg[1]` = 0 makes `pad_out` follow the flip-flop state.
- R2: `cfg[0]` sets polarity for both output kinds. With 1, `pad_out` equals the selected value. With 0, `pad_out` is its inverse.
- R3: `cfg[2]` = 1 clocks the flip-flop from `clk_a`, and `cfg[2]` = 0 clocks it from `clk_b`. Rising edges of the clock that is not selected leave the state unchanged.
- R4: `fb_out` comes from the pin when `cfg[3]` equals `cfg[1]`. Otherwise it carries the raw flip-flop state, with no polarity applied. The pin value is `pad_out` while `oe_term` is 1.
- R5: `ar_term` high clears the flip-flop to 0 at once, with no clock edge.
- R6: `sp_term` high sets the flip-flop to 1 at the next rising edge of the selected clock, and not before that edge.
- R7: When `ar_term` and `sp_term` are both high at a selected edge, the flip-flop stays 0.
- R8: While `por_n` is low, the flip-flop is 0. An active-low registered cell therefore drives `pad_out` = 1.
- R9: `pad_oe` equals `oe_term`. While `oe_term` is 0, pin feedback returns `pad_in`.
- R10: With `pl_en` = 1 and `pl_secure` = 0, a selected edge loads `pl_val`. This overrides both `sp_term` and `sop_term`.
- R11: With `pl_secure` = 1, `pl_en` is ignored and the edge loads the normal next value (`sop_term` when no set is pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First candidate clock |
| clk_b | input | 1 | Second candidate clock |
| por_n | input | 1 | Power-up clear, active low, asynchronous |
| cfg | input | 4 | Bit 3 feedback swap, bit 2 clock pick, bit 1 combinational, bit 0 active high |
| sop_term | input | 1 | Sum-of-products result |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Asynchronous clear term |
| sp_term | input | 1 | Synchronous set term |
| pl_en | input | 1 | Preload request |
| pl_val | input | 1 | Preload value |
| pl_secure | input | 1 | Security flag that blocks preload |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback into the logic array |

## Verification
The combinational paths (R1, R2, R4, R9) and the asynchronous clear (R5, R8) must settle without any clock edge. The bench checks them 1 ns after it changes an input, while both clocks are held low. Register results (R3, R6, R7, R10, R11) are due at the first rising edge of the selected clock. The bench gates each clock so that exactly one edge occurs, and samples on the falling half-cycle after that edge. The R6 check also samples before the edge, to confirm the set does not act early. A full sweep covers all 16 configurations with every combination of sum, enable, pad level and stored state.

// File: rtl/pldc_pkg.sv
`timescale 1ns/1ps
package pldc_pkg;
    localparam int CFG_BITS = 4;

    // Field order matches the cfg port: bit 3 first.
    typedef struct packed {
        logic fb_swap;   // invert register-versus-pin feedback choice
        logic clk_pick;  // 1: clk_a, 0: clk_b
        logic comb_out;  // 1: bypass the flip-flop
        logic act_high;  // 1: active-high pad
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_state_t;
endpackage

// File: rtl/pldc_clk_pick.sv
`timescale 1ns/1ps
module pldc_clk_pick (
    input  logic clk_a,
    input  logic clk_b,
    input  logic pick_a,
    output logic clk_o
);
    // Selection is expected to change only while both clocks are low.
    assign clk_o = pick_a ? clk_a : clk_b;
endmodule

// File: rtl/pldc_reg.sv
`timescale 1ns/1ps
module pldc_reg
    import pldc_pkg::*;
#(
    parameter logic INIT_Q = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic ar,
    input  logic sp,
    input  logic d,
    input  logic pl_en,
    input  logic pl_val,
    input  logic pl_secure,
    output logic q
);
    localparam cell_state_t RESET_ST = '{q: INIT_Q};

    cell_state_t st_d, st_q;
    logic        pl_hit;

    always_comb begin
        pl_hit = pl_en & ~pl_secure;
        st_d   = st_q;
        if (pl_hit) begin
            st_d.q = pl_val;
        end else if (sp) begin
            st_d.q = 1'b1;
        end else begin
            st_d.q = d;
        end
    end

    always_ff @(posedge clk or negedge por_n or posedge ar) begin
        if (!por_n) begin
            st_q <= RESET_ST;
        end else if (ar) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

    // Clear term holds the state at 0 at every edge it covers (R5, R7).
    assert_clear_holds_R5: assert property (@(posedge clk) disable iff (!por_n)
        ar |-> !q);

    // Set lands on the next edge when no preload is granted (R6).
    assert_set_next_edge_R6: assert property (@(posedge clk) disable iff (!por_n || ar)
        (sp && !(pl_en && !pl_secure)) |=> q);

    // Granted preload stores the requested value (R10).
    assert_preload_loads_R10: assert property (@(posedge clk) disable iff (!por_n || ar)
        (pl_en && !pl_secure) |=> (q == $past(pl_val)));

    // Secured preload falls back to the data input (R11).
    assert_secure_blocks_R11: assert property (@(posedge clk) disable iff (!por_n || ar)
        (pl_en && pl_secure && !sp) |=> (q == $past(d)));
endmodule

// File: rtl/pldc_out_path.sv
`timescale 1ns/1ps
module pldc_out_path (
    input  logic fb_swap,
    input  logic comb_out,
    input  logic act_high,
    input  logic sop,
    input  logic oe,
    input  logic q,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic fb
);
    logic core_val;
    logic pin_val;
    logic use_pin;

    always_comb begin
        core_val = comb_out ? sop : q;
        pad_out  = act_high ? core_val : ~core_val;
        pad_oe   = oe;
        pin_val  = oe ? pad_out : pad_in;
        use_pin  = (fb_swap == comb_out);
        fb       = use_pin ? pin_val : q;
    end
endmodule

// File: rtl/pldc_out_cell.sv
`timescale 1ns/1ps
module pldc_out_cell
    import pldc_pkg::*;
(
    input  logic                clk_a,
    input  logic                clk_b,
    input  logic                por_n,
    input  logic [CFG_BITS-1:0] cfg,
    input  logic                sop_term,
    input  logic                oe_term,
    input  logic                ar_term,
    input  logic                sp_term,
    input  logic                pl_en,
    input  logic                pl_val,
    input  logic                pl_secure,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                fb_out
);
    cell_cfg_t cfg_s;
    logic      clk_sel;
    logic      reg_q;

    assign cfg_s = cell_cfg_t'(cfg);

    pldc_clk_pick u_clk_pick (
        .clk_a  (clk_a),
        .clk_b  (clk_b),
        .pick_a (cfg_s.clk_pick),
        .clk_o  (clk_sel)
    );

    pldc_reg #(.INIT_Q(1'b0)) u_reg (
        .clk       (clk_sel),
        .por_n     (por_n),
        .ar        (ar_term),
        .sp        (sp_term),
        .d         (sop_term),
        .pl_en     (pl_en),
        .pl_val    (pl_val),
        .pl_secure (pl_secure),
        .q         (reg_q)
    );

    pldc_out_path u_out_path (
        .fb_swap  (cfg_s.fb_swap),
        .comb_out (cfg_s.comb_out),
        .act_high (cfg_s.act_high),
        .sop      (sop_term),
        .oe       (oe_term),
        .q        (reg_q),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .fb       (fb_out)
    );

    // Driven pin feeds back exactly the driven value (R4).
    assert_pin_fb_driven_R4: assert property (@(posedge clk_sel) disable iff (!por_n)
        (oe_term && (cfg[3] == cfg[1])) |-> (fb_out == pad_out));

    // Undriven pin feeds back the pad level (R9).
    assert_pin_fb_input_R9: assert property (@(posedge clk_sel) disable iff (!por_n)
        (!oe_term && (cfg[3] == cfg[1])) |-> (fb_out == pad_in));
endmodule

// File: tb/pldc_out_cell_bench.sv
`timescale 1ns/1ps
module pldc_out_cell_bench;
    logic       clk = 1'b0;
    logic       a_en = 1'b0;
    logic       clk_a;
    logic       clk_b = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] cfg = 4'b1100;
    logic       sop_term = 1'b0, oe_term = 1'b1, ar_term = 1'b0, sp_term = 1'b0;
    logic       pl_en = 1'b0, pl_val = 1'b0, pl_secure = 1'b0, pad_in = 1'b0;
    logic       pad_out, pad_oe, fb_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;
    assign clk_a = clk & a_en;

    pldc_out_cell u_pldc_out_cell (
        .clk_a(clk_a), .clk_b(clk_b), .por_n(por_n), .cfg(cfg),
        .sop_term(sop_term), .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term),
        .pl_en(pl_en), .pl_val(pl_val), .pl_secure(pl_secure), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // One rising edge on clk_a; returns on the following falling half.
    task automatic tick_a();
        a_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        a_en = 1'b0;
        #1;
    endtask

    // One isolated pulse on clk_b while clk is low.
    task automatic pulse_b();
        @(negedge clk);
        #1 clk_b = 1'b1;
        #1 clk_b = 1'b0;
        #1;
    endtask

    task automatic set_q(input logic v);
        @(negedge clk);
        cfg = 4'b0100;
        ar_term = 1'b0; sp_term = 1'b0; pl_secure = 1'b0;
        pl_en = 1'b1; pl_val = v;
        tick_a();
        pl_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: power-up clear, active-low registered, register feedback
        @(negedge clk); @(negedge clk); #1;
        chk("R8 pad_out in reset", pad_out, 1'b1);
        chk("R8 fb in reset", fb_out, 1'b0);
        @(negedge clk);
        por_n = 1'b1;
        #1;
        chk("R8 pad_out after release", pad_out, 1'b1);

        // R1 R2 R4 R9: sweep all configurations with both clocks idle
        for (int qv = 0; qv < 2; qv++) begin
            set_q(qv[0]);
            for (int c = 0; c < 16; c++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int o = 0; o < 2; o++) begin
                        for (int p = 0; p < 2; p++) begin
                            logic core, e_out, pinv, e_fb;
                            cfg = c[3:0]; sop_term = s[0]; oe_term = o[0]; pad_in = p[0];
                            #1;
                            core  = c[1] ? s[0] : qv[0];
                            e_out = c[0] ? core : ~core;
                            pinv  = o[0] ? e_out : p[0];
                            e_fb  = (c[3] == c[1]) ? pinv : qv[0];
                            chk("R1 R2 pad_out", pad_out, e_out);
                            chk("R9 pad_oe", pad_oe, o[0]);
                            chk("R4 R9 fb_out", fb_out, e_fb);
                        end
                    end
                end
            end
        end

        // R3: clock selection
        set_q(1'b0);
        cfg = 4'b1001; oe_term = 1'b1; sop_term = 1'b1;
        tick_a();
        chk("R3 clk_a ignored when clk_b picked", fb_out, 1'b0);
        pulse_b();
        chk("R3 clk_b loads", fb_out, 1'b1);
        cfg = 4'b1101; sop_term = 1'b0;
        pulse_b();
        chk("R3 clk_b ignored when clk_a picked", fb_out, 1'b1);
        tick_a();
        chk("R3 clk_a loads", fb_out, 1'b0);

        // R5: asynchronous clear
        sop_term = 1'b1;
        tick_a();
        chk("R5 setup q=1", pad_out, 1'b1);
        sop_term = 1'b0;
        ar_term = 1'b1;
        #1;
        chk("R5 clear without edge fb", fb_out, 1'b0);
        chk("R5 clear without edge pad", pad_out, 1'b0);
        ar_term = 1'b0;

        // R6: synchronous set, active-low pad
        @(negedge clk);
        cfg = 4'b1100; sp_term = 1'b1; sop_term = 1'b0;
        #1;
        chk("R6 no early set", pad_out, 1'b1);
        tick_a();
        chk("R6 set at edge fb", fb_out, 1'b1);
        chk("R6 set at edge pad", pad_out, 1'b0);

        // R7: clear beats set
        ar_term = 1'b1;
        tick_a();
        chk("R7 clear wins", fb_out, 1'b0);
        ar_term = 1'b0; sp_term = 1'b0;

        // R10: preload beats data and set
        pl_en = 1'b1; pl_val = 1'b1;
        tick_a();
        chk("R10 preload 1", fb_out, 1'b1);
        pl_val = 1'b0; sp_term = 1'b1;
        tick_a();
        chk("R10 preload beats set", fb_out, 1'b0);
        sp_term = 1'b0;

        // R11: secured preload ignored
        pl_secure = 1'b1; pl_val = 1'b1; sop_term = 1'b0;
        tick_a();
        chk("R11 secure blocks preload", fb_out, 1'b0);
        pl_val = 1'b0; sop_term = 1'b1;
        tick_a();
        chk("R11 secure loads data", fb_out, 1'b1);
        pl_en = 1'b0; pl_secure = 1'b0;

        // R9: undriven pin in combinational mode
        cfg = 4'b1111; oe_term = 1'b0; pad_in = 1'b1; sop_term = 1'b0;
        #1;
        chk("R9 pin feedback from pad_in", fb_out, 1'b1);
        chk("R9 enable low", pad_oe, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule